// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

This block gathers eight interrupt inputs, holds them in a request register and picks the most urgent one. The host reaches it through a byte-wide register port with two addresses. The host never runs an acknowledge cycle. To service an interrupt it writes a poll command and then reads address 0. That read returns the number of the winning input and marks that input as in service. The host retires the input with a specific end-of-interrupt command. Each input is edge- or level-triggered, chosen by one bit per input in an external control vector.

Priority rotates. Software names the input with the lowest priority, and the order runs upward from the input after it, wrapping past 7 back to 0. An input in service blocks itself and every input below it. A level request on input 7 can be withdrawn between the moment the interrupt line was raised and the poll read. In that case the read still reports input 7 but leaves in-service bit 7 clear. The host can then read the in-service register and see that the request was spurious. The block also gives a one-cycle flag for this case.

Top module: `poll_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF, the request and in-service registers read 0, input 7 is the lowest priority (input 0 the highest), address-0 reads select the request register, and `int_out` is low.
- R2: An address-0 write with bit 4 set starts initialization. It clears the in-service register, restores the reset priority and the request-register read selection, and leaves the mask unchanged. The address-1 writes that follow are then absorbed and do not touch the mask: one, plus one more when bit 1 of that write is clear, plus one more when bit 0 is set. Later address-1 writes load the mask, and address-1 reads return it.
- R3: Mask bit n set hides input n from poll reads and from `int_out`. The request stays visible in the request register.
- R4: With `trig_level[n]`=1, request bit n equals `irq_in[n]` as sampled at the previous clock edge. With `trig_level[n]`=0, a rising edge sets request bit n at the next edge, and the bit stays set until a poll read grants input n.
- R5: An address-0 write with bit 3 set and bit 4 clear is a select command; with bit 2 also set it arms a poll. The next address-0 read returns 0x80|n when input n is the serviceable winner. That read sets in-service bit n and clears an edge request n. With no winner, and `int_out` low in the previous cycle, the read returns 0x00. Every address-0 read disarms the poll.
- R6: A command write (address 0, bits 4 and 3 clear) of 0xC0|n makes input n the lowest priority. Priority then runs n+1, n+2, ... wrapping, down to n.
- R7: A request whose priority is at or below that of the highest-priority in-service bit is not reported and does not raise `int_out`.
- R8: A command write of 0x60|n clears in-service bit n. Command writes with other values in bits 7-5 change nothing.
- R9: A select command with bit 1 set makes unarmed address-0 reads return the in-service register (bit 0 = 1) or the request register (bit 0 = 0). The choice holds until changed.
- R10: Suppose `int_out` was high in the cycle before a poll read and no request is serviceable at the read. The read then returns 0x87, leaves the in-service register unchanged, and `spur_pulse` is high in the following cycle.
- R11: `int_out` is high exactly while some unmasked request outranks every in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| addr | input | 1 | Register port address (0 = command/status, 1 = mask/init data) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high, 0 otherwise |
| irq_in | input | 8 | Interrupt request inputs |
| trig_level | input | 8 | Per-input trigger select: 1 level, 0 rising edge |
| int_out | output | 1 | Serviceable request pending |
| spur_pulse | output | 1 | One-cycle flag after a spurious input-7 poll read |

## Verification
The spurious case is the hardest to reach from the ports. It needs `int_out` raised in one cycle and the request gone in the very next cycle, which is when the poll read happens. The stimulus uses a level-triggered input 7. It drops that input in the same cycle as the poll-arming write, so the request register falls exactly at the edge before the read. Nested service is reached the same way: a lower-priority edge request is left pending behind an in-service bit, then retired by specific EOIs in a chosen order.

// File: rtl/pic_pkg.sv
// Package: shared command decoding for the polled interrupt controller.
// Assumes 8-bit command words. Bits 7-5 of an operation command select its kind.
package pic_pkg;

    typedef enum logic [2:0] {
        OP_SPEC_EOI = 3'b011,
        OP_SET_LOW  = 3'b110
    } op_cmd_e;

    // Count of address-1 data words that follow an initialization word.
    function automatic logic [1:0] init_words(input logic [7:0] w);
        return 2'd1 + {1'b0, ~w[1]} + {1'b0, w[0]};
    endfunction

endpackage

// File: rtl/pic_reqreg.sv
// Request register: one latch per input, edge- or level-triggered by trig_level.
// Assumes inputs are already synchronous to clk. ack_vec clears edge-latched bits,
// and a new rising edge in the same cycle wins over the clear.
module pic_reqreg #(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] irq_in,
    input  logic [N_IN-1:0] trig_level,
    input  logic [N_IN-1:0] ack_vec,
    output logic [N_IN-1:0] irr
);

    logic [N_IN-1:0] prev_q;

    for (genvar i = 0; i < N_IN; i++) begin : g_lane
        // Track the input and update this request bit per its trigger mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                irr[i]    <= 1'b0;
            end else begin
                prev_q[i] <= irq_in[i];
                if (trig_level[i])
                    irr[i] <= irq_in[i];
                else
                    irr[i] <= (irr[i] & ~ack_vec[i]) | (irq_in[i] & ~prev_q[i]);
            end
        end
    end

endmodule

// File: rtl/pic_resolver.sv
// Rotating priority resolver. Walks the inputs from highest priority (low_id+1)
// to lowest (low_id). It stops at the first in-service bit, or at the first
// pending request. Assumes N_IN is a power of two so the index wraps naturally.
module pic_resolver #(
    parameter int N_IN = 8,
    localparam int ID_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] pend,
    input  logic [N_IN-1:0] isr,
    input  logic [ID_W-1:0] low_id,
    output logic            found,
    output logic [ID_W-1:0] win_id
);

    // Scan in priority order; an in-service bit blocks everything below it.
    always_comb begin
        logic            blocked;
        logic [ID_W-1:0] idx;
        found   = 1'b0;
        win_id  = '0;
        blocked = 1'b0;
        idx     = '0;
        for (int k = 0; k < N_IN; k++) begin
            idx = ID_W'(low_id + ID_W'(k) + ID_W'(1));
            if (!blocked && !found) begin
                if (isr[idx])
                    blocked = 1'b1;
                else if (pend[idx]) begin
                    found  = 1'b1;
                    win_id = idx;
                end
            end
        end
    end

endmodule

// File: rtl/pic_ctrl.sv
// Register port, in-service and mask state, and poll handling.
// Assumes reads and writes never share a cycle. rdata is combinational and
// valid while rd_en is high. A poll read grants the winner at that clock edge.
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int DW   = 8,
    localparam int ID_W = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    input  logic [N_IN-1:0] irr,
    input  logic            found,
    input  logic [ID_W-1:0] win_id,
    output logic [N_IN-1:0] imr,
    output logic [N_IN-1:0] isr,
    output logic [ID_W-1:0] low_id,
    output logic [N_IN-1:0] ack_vec,
    output logic [DW-1:0]   rdata,
    output logic            poll_armed,
    output logic            int_prev,
    output logic            spur_pulse
);

    logic       rd_isr;
    logic [1:0] init_left;
    logic       poll_rd;
    logic       grant;
    logic       spur_hit;

    // Decode the poll read and its grant.
    always_comb begin
        poll_rd  = rd_en & ~addr & poll_armed;
        grant    = poll_rd & found;
        spur_hit = poll_rd & ~found & int_prev;
        ack_vec  = grant ? (N_IN'(1) << win_id) : '0;
    end

    // Read multiplexer: mask, poll word, or the selected status register.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr)
                rdata = DW'(imr);
            else if (poll_armed) begin
                rdata[DW-1]     = found | int_prev;
                rdata[ID_W-1:0] = found ? win_id : {ID_W{int_prev}};
            end else
                rdata = rd_isr ? DW'(isr) : DW'(irr);
        end
    end

    // Register state updates from writes and poll reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr        <= '1;
            isr        <= '0;
            low_id     <= ID_W'(N_IN - 1);
            rd_isr     <= 1'b0;
            poll_armed <= 1'b0;
            init_left  <= '0;
            int_prev   <= 1'b0;
            spur_pulse <= 1'b0;
        end else begin
            int_prev   <= found & ~poll_rd;
            spur_pulse <= spur_hit;
            if (rd_en && !addr)
                poll_armed <= 1'b0;
            if (grant)
                isr <= isr | ack_vec;
            if (wr_en) begin
                if (!addr) begin
                    if (wdata[4]) begin
                        isr        <= '0;
                        low_id     <= ID_W'(N_IN - 1);
                        rd_isr     <= 1'b0;
                        poll_armed <= 1'b0;
                        init_left  <= init_words(wdata[7:0]);
                    end else if (wdata[3]) begin
                        if (wdata[2])
                            poll_armed <= 1'b1;
                        if (wdata[1])
                            rd_isr <= wdata[0];
                    end else begin
                        case (op_cmd_e'(wdata[7:5]))
                            OP_SPEC_EOI: isr[wdata[ID_W-1:0]] <= 1'b0;
                            OP_SET_LOW:  low_id <= wdata[ID_W-1:0];
                            default: ;
                        endcase
                    end
                end else begin
                    if (init_left != 2'd0)
                        init_left <= init_left - 2'd1;
                    else
                        imr <= wdata[N_IN-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/poll_irq_ctrl.sv
// Top: polled rotating-priority interrupt controller with a two-address byte port.
// Assumes N_IN is a power of two and no wider than DW. Host service is by poll
// reads only.
module poll_irq_ctrl #(
    parameter int N_IN = 8,
    parameter int DW   = 8,
    localparam int ID_W = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [N_IN-1:0] irq_in,
    input  logic [N_IN-1:0] trig_level,
    output logic            int_out,
    output logic            spur_pulse
);

    logic [N_IN-1:0] irr;
    logic [N_IN-1:0] imr;
    logic [N_IN-1:0] isr;
    logic [N_IN-1:0] ack_vec;
    logic [N_IN-1:0] pend;
    logic [ID_W-1:0] low_id;
    logic [ID_W-1:0] win_id;
    logic            found;
    logic            int_prev;
    logic            poll_armed;

    // Unmasked requests feed the resolver; its verdict is the interrupt line.
    always_comb begin
        pend    = irr & ~imr;
        int_out = found;
    end

    pic_reqreg #(.N_IN(N_IN)) u_reqreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .trig_level (trig_level),
        .ack_vec    (ack_vec),
        .irr        (irr)
    );

    pic_resolver #(.N_IN(N_IN)) u_resolver (
        .pend   (pend),
        .isr    (isr),
        .low_id (low_id),
        .found  (found),
        .win_id (win_id)
    );

    pic_ctrl #(.N_IN(N_IN), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .irr        (irr),
        .found      (found),
        .win_id     (win_id),
        .imr        (imr),
        .isr        (isr),
        .low_id     (low_id),
        .ack_vec    (ack_vec),
        .rdata      (rdata),
        .poll_armed (poll_armed),
        .int_prev   (int_prev),
        .spur_pulse (spur_pulse)
    );

endmodule

// File: rtl/pic_checker.sv
// Checker bound into poll_irq_ctrl. It relates register-port activity to the
// resolver verdict and the stored in-service, mask and request state.
module pic_checker #(
    parameter int N_IN = 8,
    parameter int DW   = 8,
    localparam int ID_W = $clog2(N_IN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            addr,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   rdata,
    input logic [N_IN-1:0] irq_in,
    input logic [N_IN-1:0] trig_level,
    input logic            int_out,
    input logic            spur_pulse,
    input logic [N_IN-1:0] irr,
    input logic [N_IN-1:0] imr,
    input logic [N_IN-1:0] isr,
    input logic            found,
    input logic [ID_W-1:0] win_id,
    input logic            int_prev,
    input logic            poll_armed
);

    AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && poll_armed && found) |=> isr[$past(win_id)]); // R5

    AST_GRANT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && poll_armed && found) |-> (rdata[DW-1] && rdata[ID_W-1:0] == win_id)); // R5

    AST_READ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && !wr_en) |=> !poll_armed); // R5

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !addr && wdata[4:3] == 2'b00 && wdata[7:5] == 3'b011)
        |=> !isr[$past(wdata[ID_W-1:0])]); // R8

    AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (irr[win_id] && !imr[win_id])); // R3

    AST_WINNER_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> !isr[win_id]); // R7

    AST_SPUR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !addr && poll_armed && !found && int_prev) |=> (spur_pulse && $stable(isr))); // R10

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((irr & $past(trig_level)) == ($past(irq_in) & $past(trig_level)))); // R4

    AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != '0)); // R11

endmodule

bind poll_irq_ctrl pic_checker #(.N_IN(N_IN), .DW(DW)) u_pic_checker (.*);

// File: tb/poll_irq_ctrl_bench.sv
// Bench: behavioural reference model stepped every clock plus directed expectations.
module poll_irq_ctrl_bench;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] irq_in = '0;
    logic [7:0] trig_level = '0;
    logic       int_out;
    logic       spur_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] irq_v = '0;
    logic [7:0] lvl_v = '0;
    logic [7:0] last_rd;
    logic       last_spur;

    // reference model state
    logic [7:0] m_imr, m_isr, m_irr, m_prev;
    int         m_low, m_left;
    bit         m_rdisr, m_armed, m_intprev, m_spur;

    always #(PERIOD/2) clk = ~clk;

    poll_irq_ctrl u_poll_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .trig_level(trig_level),
        .int_out(int_out), .spur_pulse(spur_pulse)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_imr = 8'hFF; m_isr = '0; m_irr = '0; m_prev = '0;
        m_low = 7; m_left = 0;
        m_rdisr = 0; m_armed = 0; m_intprev = 0; m_spur = 0;
    endtask

    // Winner by rank: rank 0 is the input just above the lowest-priority one.
    task automatic model_win(output bit f, output int id);
        int best_req, best_isr;
        best_req = 8; best_isr = 8; id = 0;
        for (int i = 0; i < 8; i++) begin
            int r;
            r = (i + 7 - m_low) % 8;
            if (m_isr[i] && r < best_isr) best_isr = r;
            if (m_irr[i] && !m_imr[i] && r < best_req) begin best_req = r; id = i; end
        end
        f = (best_req < best_isr);
    endtask

    // One clock: drive, compare the model with the outputs, advance the model.
    task automatic cyc(input bit w, input bit r, input bit a, input logic [7:0] d, input string tag);
        bit f, prd;
        int id;
        logic [7:0] exp_rd;
        logic [7:0] irr_n;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; irq_in = irq_v; trig_level = lvl_v;
        #(PERIOD/4);
        model_win(f, id);
        chk({tag, " int_out"}, {7'd0, int_out}, {7'd0, f});
        chk({tag, " spur_pulse"}, {7'd0, spur_pulse}, {7'd0, m_spur});
        if (r) begin
            if (a) exp_rd = m_imr;
            else if (m_armed) exp_rd = f ? (8'h80 | 8'(id)) : (m_intprev ? 8'h87 : 8'h00);
            else exp_rd = m_rdisr ? m_isr : m_irr;
            chk({tag, " rdata"}, rdata, exp_rd);
        end
        last_rd = rdata;
        last_spur = spur_pulse;
        @(posedge clk);
        prd = r && !a && m_armed;
        for (int i = 0; i < 8; i++)
            irr_n[i] = lvl_v[i] ? irq_v[i]
                     : ((m_irr[i] && !(prd && f && id == i)) || (irq_v[i] && !m_prev[i]));
        m_spur = prd && !f && m_intprev;
        m_intprev = f && !prd;
        m_prev = irq_v;
        m_irr = irr_n;
        if (prd && f) m_isr[id] = 1'b1;
        if (r && !a) m_armed = 0;
        if (w && !a) begin
            if (d[4]) begin
                m_isr = '0; m_low = 7; m_rdisr = 0; m_armed = 0;
                m_left = 1 + (d[1] ? 0 : 1) + (d[0] ? 1 : 0);
            end else if (d[3]) begin
                if (d[2]) m_armed = 1;
                if (d[1]) m_rdisr = d[0];
            end else if (d[7:5] == 3'b011) m_isr[d[2:0]] = 1'b0;
            else if (d[7:5] == 3'b110) m_low = int'(d[2:0]);
        end else if (w && a) begin
            if (m_left > 0) m_left--;
            else m_imr = d;
        end
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 8'h00, tag);
    endtask

    task automatic wr(input bit a, input logic [7:0] d, input string tag);
        cyc(1, 0, a, d, tag);
    endtask

    task automatic rd_exp(input bit a, input logic [7:0] exp, input string tag);
        cyc(0, 1, a, 8'h00, tag);
        chk({tag, " directed"}, last_rd, exp);
    endtask

    task automatic pulse(input logic [7:0] m, input string tag);
        irq_v = irq_v | m; idle(tag);
        irq_v = irq_v & ~m; idle(tag);
    endtask

    task automatic poll_exp(input logic [7:0] exp, input string tag);
        wr(0, 8'h0C, tag);
        rd_exp(0, exp, tag);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        idle("R1");
        rd_exp(1, 8'hFF, "R1");
        rd_exp(0, 8'h00, "R1");
        // R2 init sequence with three data words
        wr(0, 8'h11, "R2");
        wr(1, 8'h00, "R2"); wr(1, 8'h04, "R2"); wr(1, 8'h01, "R2");
        rd_exp(1, 8'hFF, "R2");
        wr(1, 8'h00, "R2");
        rd_exp(1, 8'h00, "R2");
        // R4 edge latch, R5 poll grant
        pulse(8'h08, "R4");
        rd_exp(0, 8'h08, "R4");
        poll_exp(8'h83, "R5");
        rd_exp(0, 8'h00, "R5");
        wr(0, 8'h0B, "R9");
        rd_exp(0, 8'h08, "R9");
        // R7 blocking by in-service input 3, nesting with input 1
        pulse(8'h20, "R7");
        poll_exp(8'h00, "R7");
        pulse(8'h02, "R7");
        poll_exp(8'h81, "R7");
        rd_exp(0, 8'h0A, "R9");
        // R8 specific EOI and an ignored command code
        wr(0, 8'h61, "R8");
        wr(0, 8'h20, "R8");
        rd_exp(0, 8'h08, "R8");
        wr(0, 8'h63, "R8");
        poll_exp(8'h85, "R8");
        wr(0, 8'h65, "R8");
        rd_exp(0, 8'h00, "R8");
        // R3 masking
        wr(1, 8'h40, "R3");
        pulse(8'h40, "R3");
        wr(0, 8'h0A, "R3");
        rd_exp(0, 8'h40, "R3");
        poll_exp(8'h00, "R3");
        wr(1, 8'h00, "R3");
        poll_exp(8'h86, "R3");
        wr(0, 8'h66, "R3");
        // R6 rotated priority: lowest = 2, so 4 outranks 1
        wr(0, 8'hC2, "R6");
        pulse(8'h12, "R6");
        poll_exp(8'h84, "R6");
        wr(0, 8'h64, "R6");
        poll_exp(8'h81, "R6");
        wr(0, 8'h61, "R6");
        wr(0, 8'hC7, "R6");
        // R4 level input 7
        lvl_v = 8'h80; irq_v = 8'h80;
        idle("R4");
        poll_exp(8'h87, "R4");
        rd_exp(0, 8'h80, "R4");
        wr(0, 8'h67, "R11");
        idle("R11");
        // R10 withdraw input 7 in the poll-arming cycle
        irq_v = 8'h00;
        wr(0, 8'h0C, "R10");
        rd_exp(0, 8'h87, "R10");
        idle("R10");
        chk("R10 spur_pulse directed", {7'd0, last_spur}, 8'h01);
        wr(0, 8'h0B, "R10");
        rd_exp(0, 8'h00, "R10");
        // R2 short init word (bit1 set, bit0 clear) clears in-service
        lvl_v = 8'h00;
        pulse(8'h01, "R2");
        poll_exp(8'h80, "R2");
        wr(0, 8'h12, "R2");
        wr(1, 8'h00, "R2");
        wr(1, 8'h3C, "R2");
        rd_exp(1, 8'h3C, "R2");
        wr(0, 8'h0B, "R2");
        rd_exp(0, 8'h00, "R2");
        idle("R11");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule